// File: doc/BRIEF.md
# Multi-Push Single-Pop Delay FIFO

This block is a single-clock queue. In one cycle it can take a whole batch of values, anywhere from none up to a fixed number of write lanes, and it releases at most one value per cycle. The write side carries one packed bundle of data lanes and a count. The count says how many lanes, starting at lane 0, hold real data this cycle. The read side shows the oldest stored value together with a present flag. There is no read enable. The block drains itself by one entry in every cycle in which it holds data, so downstream logic must take each value in the cycle it is shown.

The output depends only on the stored queue, so a value written in one cycle appears no earlier than the next. The rule for each update depends on whether the queue is empty:

- **Empty queue:** it simply loads the incoming batch and removes nothing.
- **Non-empty queue:** it first appends the batch behind its contents and then drops its head, in the same update.

Storage is bounded by a parameter. Values that do not fit are discarded, and a sticky flag records that this has happened.

Top module: `mpsp_delay_fifo`

## Requirements
- R1: A synchronous active-high reset empties the queue, drives `outValid` low and clears `overflow`.
- R2: When the queue is empty, a batch of k>0 values makes `outValid` high in the following cycle, and no value of the batch is removed by that update. All k values then appear, one per cycle.
- R3: Within a batch, lane 0 (bits DATA_W-1:0 of `inData`) is the oldest value and lane `inCount`-1 is the newest. Values leave in arrival order across batches.
- R4: When the queue is non-empty, the batch is appended behind the stored values and the head is removed in the same cycle. Exactly one value leaves per cycle while data is held.
- R5: `outValid` is low whenever the stored queue is empty. While it is high, `outData` is the oldest stored value. A value written in cycle t is never visible before cycle t+1.
- R6: With occ entries stored before the update, min(count, DEPTH-occ) values of the batch are accepted, taken from lane 0 upward. The newer lanes beyond that are discarded. The slot freed by the pop is not used by the same batch.
- R7: `overflow` rises in the cycle after any batch loses a value to R6, and stays high until reset.
- R8: An `inCount` above LANES is treated as LANES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | LANES*DATA_W | Write lanes; lane i occupies bits i*DATA_W +: DATA_W |
| inCount | input | $clog2(LANES+1) | Number of valid lanes this cycle, starting at lane 0 |
| outData | output | DATA_W | Oldest stored value |
| outValid | output | 1 | High when the queue holds at least one value |
| overflow | output | 1 | Sticky flag: some value was discarded for lack of room |

## Verification
The bench applies several input patterns, each aimed at a different behaviour:

- **Lone batch into an empty queue:** a batch followed by idle cycles separates the load-without-pop rule from append-then-pop. It also shows lane order and the drain to absent.
- **Out-of-range count:** a count above the lane number into an empty queue separates clamping from discarding, because it must not raise the overflow flag.
- **Back-to-back full batches:** these fill the store, expose whether the freed head slot is wrongly reused, and show that the flag is sticky.
- **Mixed random traffic:** random batch sizes, including out-of-range counts, run after a mid-run reset. The order, presence and flag are compared against a software queue model.

// File: rtl/mpsp_pkg.sv
package mpsp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic writeAny;  // at least one lane is stored this cycle
    logic popHead;   // the head entry leaves this cycle
  } fifoStrobeT;
endpackage

// File: rtl/mpsp_ctrl.sv
module mpsp_ctrl
  import mpsp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(LANES + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    inCount,
  output fifoStrobeT       strb,
  output logic [LANES-1:0] laneWe,
  output logic [PW-1:0]    wrPtr,
  output logic [PW-1:0]    rdPtr,
  output logic             outValid,
  output logic             overflow
);
  localparam int AW = ((CW > OW) ? CW : OW) + 1;

  logic [OW-1:0] occ;
  logic [OW-1:0] occNext;
  logic [AW-1:0] effCnt;
  logic [AW-1:0] roomCnt;
  logic [AW-1:0] accCnt;
  logic          tooMany;
  logic [PW:0]   wrSum;
  logic [PW-1:0] wrNext;
  logic [PW-1:0] rdNext;

  always_comb begin
    if (AW'(inCount) > AW'(LANES)) effCnt = AW'(LANES);
    else                           effCnt = AW'(inCount);
    roomCnt = AW'(DEPTH) - AW'(occ);
    tooMany = effCnt > roomCnt;
    accCnt  = tooMany ? roomCnt : effCnt;
  end

  assign strb.popHead  = (occ != '0);
  assign strb.writeAny = (accCnt != '0);
  assign outValid      = strb.popHead;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_we
      assign laneWe[i] = (AW'(i) < accCnt);
    end
  endgenerate

  always_comb begin
    wrSum = (PW + 1)'(wrPtr) + (PW + 1)'(accCnt);
    if (wrSum >= (PW + 1)'(DEPTH)) wrNext = PW'(wrSum - (PW + 1)'(DEPTH));
    else                           wrNext = PW'(wrSum);
    if (!strb.popHead)                     rdNext = rdPtr;
    else if (rdPtr == PW'(DEPTH - 1))      rdNext = '0;
    else                                   rdNext = rdPtr + 1'b1;
    occNext = occ + OW'(accCnt) - OW'(strb.popHead);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ      <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      overflow <= 1'b0;
    end else begin
      occ      <= occNext;
      wrPtr    <= wrNext;
      rdPtr    <= rdNext;
      overflow <= overflow | tooMany;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(DEPTH)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R7
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (outValid && inCount == '0) |=> (occ == $past(occ) - 1'b1)); // R4
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!outValid && inCount == '0) |=> !outValid); // R5
  AST_EMPTY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!outValid && inCount != '0) |=> outValid); // R2
endmodule

// File: rtl/mpsp_data.sv
module mpsp_data
  import mpsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int DEPTH  = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [LANES-1:0]        laneWe,
  input  logic [PW-1:0]           wrPtr,
  input  logic [PW-1:0]           rdPtr,
  input  fifoStrobeT              strb,
  output logic [DATA_W-1:0]       outData
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     laneAddr [LANES];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_addr
      logic [PW:0] rawAddr;
      assign rawAddr = (PW + 1)'(wrPtr) + (PW + 1)'(i);
      assign laneAddr[i] = (rawAddr >= (PW + 1)'(DEPTH)) ?
                           PW'(rawAddr - (PW + 1)'(DEPTH)) : PW'(rawAddr);
      if (i > 0) begin : g_thermo
        AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
          laneWe[i] |-> laneWe[i-1]); // R3
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.writeAny) begin
      for (int s = 0; s < DEPTH; s++) begin
        for (int i = 0; i < LANES; i++) begin
          if (laneWe[i] && laneAddr[i] == PW'(s))
            store[s] <= inData[i*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign outData = store[rdPtr];

  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (rst)
    strb.writeAny == laneWe[0]); // R6
endmodule

// File: rtl/mpsp_delay_fifo.sv
module mpsp_delay_fifo
  import mpsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(LANES + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [CW-1:0]           inCount,
  output logic [DATA_W-1:0]       outData,
  output logic                    outValid,
  output logic                    overflow
);
  fifoStrobeT       strb;
  logic [LANES-1:0] laneWe;
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  mpsp_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .inCount(inCount), .strb(strb), .laneWe(laneWe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .outValid(outValid), .overflow(overflow)
  );

  mpsp_data #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH)) i_data (
    .clk(clk), .rst(rst), .inData(inData), .laneWe(laneWe), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .strb(strb), .outData(outData)
  );
endmodule

// File: tb/test_mpsp_delay_fifo.sv
module test_mpsp_delay_fifo;
  localparam int DATA_W = 8;
  localparam int LANES  = 4;
  localparam int DEPTH  = 8;
  localparam int CW     = $clog2(LANES + 1);

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [LANES*DATA_W-1:0] inData = '0;
  logic [CW-1:0]           inCount = '0;
  logic [DATA_W-1:0]       outData;
  logic                    outValid;
  logic                    overflow;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] model[$];
  logic modelOvf = 1'b0;
  int seedDummy;

  always #4 clk = ~clk;

  mpsp_delay_fifo #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH)) i_mpsp_delay_fifo (
    .clk(clk), .rst(rst), .inData(inData), .inCount(inCount),
    .outData(outData), .outValid(outValid), .overflow(overflow)
  );

  function automatic int clampCount(int c);
    return (c > LANES) ? LANES : c;
  endfunction

  function automatic int acceptedCount(int c, int occ);
    int e = clampCount(c);
    return (e > DEPTH - occ) ? DEPTH - occ : e;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareOutputs(string tag);
    check(tag, "outValid", int'(outValid), (model.size() > 0) ? 1 : 0);
    if (model.size() > 0 && outValid) check(tag, "outData", int'(outData), int'(model[0]));
    check(tag, "overflow", int'(overflow), int'(modelOvf));
  endtask

  // called at a falling edge: check, drive, advance model, wait one cycle
  task automatic step(string tag, int cnt);
    int acc;
    bit wasFull;
    compareOutputs(tag);
    for (int i = 0; i < LANES; i++) inData[i*DATA_W +: DATA_W] = DATA_W'($urandom);
    inCount = CW'(cnt);
    acc = acceptedCount(cnt, model.size());
    if (acc < clampCount(cnt)) modelOvf = 1'b1;
    wasFull = model.size() > 0;
    for (int i = 0; i < acc; i++) model.push_back(inData[i*DATA_W +: DATA_W]);
    if (wasFull) void'(model.pop_front());
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    inCount = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model.delete();
    modelOvf = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'h5eed);
    @(negedge clk);
    doReset();
    // R1: reset state
    compareOutputs("R1");
    // R2 R3: lone batch of 3 into empty queue, then idle drain
    step("R2", 3);
    check("R2", "loadedValid", int'(outValid), 1);
    for (int k = 0; k < 3; k++) step("R3", 0);
    // R5: absent once drained
    step("R5", 0);
    check("R5", "absentAfterDrain", int'(outValid), 0);
    step("R5", 0);
    // R8: out-of-range count clamps, no overflow
    step("R8", 7);
    for (int k = 0; k < 4; k++) step("R8", 0);
    check("R8", "noOverflowOnClamp", int'(overflow), 0);
    step("R8", 0);
    // R4: append-then-pop with small batches
    for (int k = 0; k < 12; k++) step("R4", (k % 3 == 0) ? 2 : (k % 3));
    for (int k = 0; k < 8; k++) step("R4", 0);
    // R6 R7: full batches back to back, overflow and stickiness
    for (int k = 0; k < 4; k++) step("R6", LANES);
    for (int k = 0; k < 10; k++) step("R7", 0);
    check("R7", "stickyOverflow", int'(overflow), 1);
    // R1: mid-run reset clears overflow and queue
    doReset();
    compareOutputs("R1");
    // R4: random batches including out-of-range counts
    for (int k = 0; k < 400; k++) begin
      int c = ($urandom % 8 == 0) ? int'($urandom % 8) : int'($urandom % (LANES + 1));
      if (k > 300) c = ($urandom % 2 == 0) ? 0 : 1;
      step("R4", c);
    end
    compareOutputs("R4");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule